// File: doc/BRIEF.md
# Relative Branch and Jump Sequencer

This block holds the program counter of a small 16-bit-instruction processor and works out the address of the next instruction on every enabled cycle. Each instruction takes one word, so the normal step adds one. Two instruction categories redirect the flow. An unconditional jump adds a signed word offset to the current address. A conditional branch adds the same kind of offset only when the value read from the instruction's source register meets one of eight conditions.

The offset is six bits wide and is carried in two three-bit pieces. The pieces sit on either side of the source-register field, so that field stays in the same place in every instruction format. The block puts the pieces back together, sign-extends the result to the width of the program counter and adds it with wrap-around. The surrounding pipeline supplies the instruction word and the value already read from the source register. A step enable decides whether the counter advances in a given cycle.

Top module: `flow_ctrl_unit`

## Requirements
- R1: A high `rst` at a rising clock edge sets `pc` to zero in that cycle, whatever `step` and the other inputs are.
- R2: When `rst` is low and `step` is low, `pc` keeps its value across the edge, whatever `instr` holds.
- R3: When `step` is high and `instr[15:13]` is any of 000 to 101, `pc` becomes `pc + 1` modulo 2^PC_W. The all-ones address wraps to zero.
- R4: The relative offset is the 6-bit two's-complement value {`instr[8:6]`, `instr[2:0]`}, with bits 8:6 as the upper half. It is sign-extended, so it spans +31 to -32 words. Bits 5:3 (the source-register field) never change it.
- R5: When `step` is high and `instr[15:13]` is 111 (jump), `pc` becomes `pc + offset`. Neither `sa_val` nor `instr[12:9]` affects the result.
- R6: When `instr[15:13]` is 110 (branch), `instr[11:9]` selects the condition: 000 never, 001 always, 010 negative, 011 zero, 100 not negative, 101 not zero, 110 positive, 111 zero or negative. `instr[12]` has no effect.
- R7: On a stepped branch whose condition holds, `pc` becomes `pc + offset`. When the condition fails, `pc` becomes `pc + 1`.
- R8: The relative add wraps modulo 2^PC_W in both directions, so a backward offset from a small address lands near the top of the address space.
- R9: Branch conditions treat `sa_val` as a signed two's-complement number. Its MSB is the sign, so the most negative value counts as negative and the largest positive value counts as positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| step | input | 1 | Advance enable; the counter moves only when high |
| instr | input | 16 | Current instruction word |
| sa_val | input | DATA_W (16) | Value read from the source register named in bits 5:3 |
| pc | output | PC_W (16) | Current program counter |

## Verification
The hardest states to reach from the ports are the address extremes. The counter cannot be loaded, and a normal program sits in low memory, so it never crosses the all-ones/zero boundary on its own. The stimulus gets there with a short backward jump from a small address: the counter lands near the top of the address space, and plain steps then carry it back across zero. The condition table is swept at the signed extremes and at -1, 0 and +1 of the register value, with bit 12 both set and clear. Long random runs follow, which mix jumps, branches, stalls and the occasional reset.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int INSTR_W = 16;
    localparam int OFS_W   = 6;

    localparam logic [2:0] PFX_BRANCH = 3'b110;
    localparam logic [2:0] PFX_JUMP   = 3'b111;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_JUMP   = 2'd2
    } flow_kind_e;

    typedef enum logic [2:0] {
        C_NEVER   = 3'b000,
        C_ALWAYS  = 3'b001,
        C_NEG     = 3'b010,
        C_ZERO    = 3'b011,
        C_NONNEG  = 3'b100,
        C_NONZERO = 3'b101,
        C_POS     = 3'b110,
        C_NONPOS  = 3'b111
    } cond_e;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output flow_kind_e         kind,
    output cond_e              cond,
    output logic [PC_W-1:0]    offset
);

    logic [2:0]       prefix;
    logic [OFS_W-1:0] raw_ofs;

    always_comb begin
        prefix  = instr[15:13];
        cond    = cond_e'(instr[11:9]);
        // upper half of the offset above the source field, lower half below
        raw_ofs = {instr[8:6], instr[2:0]};
        case (prefix)
            PFX_BRANCH: kind = FLOW_BRANCH;
            PFX_JUMP:   kind = FLOW_JUMP;
            default:    kind = FLOW_SEQ;
        endcase
    end

    generate
        if (PC_W > OFS_W) begin : g_extend
            assign offset = {{(PC_W-OFS_W){raw_ofs[OFS_W-1]}}, raw_ofs};
        end else begin : g_trunc
            assign offset = raw_ofs[PC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sa_val,
    input  cond_e             cond,
    output logic              holds
);

    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = sa_val[DATA_W-1];
        is_zero = (sa_val == '0);
        case (cond)
            C_NEVER:   holds = 1'b0;
            C_ALWAYS:  holds = 1'b1;
            C_NEG:     holds = is_neg;
            C_ZERO:    holds = is_zero;
            C_NONNEG:  holds = !is_neg;
            C_NONZERO: holds = !is_zero;
            C_POS:     holds = !is_neg && !is_zero;
            C_NONPOS:  holds = is_neg || is_zero;
            default:   holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/flow_pc.sv
module flow_pc
    import flow_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  flow_kind_e      kind,
    input  logic            cond_ok,
    input  logic [PC_W-1:0] offset,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;
    logic      redirect;

    always_comb begin
        st_d     = st_q;
        redirect = (kind == FLOW_JUMP) || ((kind == FLOW_BRANCH) && cond_ok);
        if (rst) begin
            st_d.pc = '0;
        end else if (step) begin
            st_d.pc = redirect ? (st_q.pc + offset) : (st_q.pc + ONE);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc = st_q.pc;

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (pc == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> (pc == $past(pc)));

    a_r3_seq_inc: assert property (@(posedge clk) disable iff (rst)
        (step && kind == FLOW_SEQ) |=> (pc == $past(pc) + ONE));

    a_r5_jump_rel: assert property (@(posedge clk) disable iff (rst)
        (step && kind == FLOW_JUMP) |=> (pc == $past(pc) + $past(offset)));

    a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
        (step && kind == FLOW_BRANCH && !cond_ok) |=> (pc == $past(pc) + ONE));

    a_r7_taken: assert property (@(posedge clk) disable iff (rst)
        (step && kind == FLOW_BRANCH && cond_ok) |=> (pc == $past(pc) + $past(offset)));

endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
    import flow_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  sa_val,
    output logic [PC_W-1:0]    pc
);

    flow_kind_e      kind;
    cond_e           cond;
    logic [PC_W-1:0] offset;
    logic            cond_ok;

    flow_decode #(.PC_W(PC_W)) u_decode (
        .instr  (instr),
        .kind   (kind),
        .cond   (cond),
        .offset (offset)
    );

    flow_cond #(.DATA_W(DATA_W)) u_cond (
        .sa_val (sa_val),
        .cond   (cond),
        .holds  (cond_ok)
    );

    flow_pc #(.PC_W(PC_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .kind    (kind),
        .cond_ok (cond_ok),
        .offset  (offset),
        .pc      (pc)
    );

    // R6: a stepped branch-if-zero on a zero register must redirect
    a_r6_zero_taken: assert property (@(posedge clk) disable iff (rst)
        (step && instr[15:13] == 3'b110 && instr[11:9] == 3'b011 && sa_val == '0)
        |=> (pc == $past(pc) + $past(offset)));

    // R9: a negative register never satisfies the "positive" condition
    a_r9_neg_not_pos: assert property (@(posedge clk) disable iff (rst)
        (step && instr[15:13] == 3'b110 && instr[11:9] == 3'b110 && sa_val[DATA_W-1])
        |=> (pc == $past(pc) + PC_W'(1)));

endmodule

// File: tb/flow_ctrl_unit_bench.sv
module flow_ctrl_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] sa_val = '0;
    logic [15:0] pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] mpc = '0;

    always #10 clk = ~clk;

    flow_ctrl_unit u_flow_ctrl_unit (
        .clk(clk), .rst(rst), .step(step),
        .instr(instr), .sa_val(sa_val), .pc(pc)
    );

    function automatic logic cond_ok(input logic [2:0] c, input logic [15:0] v);
        int s;
        s = $signed(v);
        case (c)
            3'b000: return 1'b0;
            3'b001: return 1'b1;
            3'b010: return s < 0;
            3'b011: return s == 0;
            3'b100: return s >= 0;
            3'b101: return s != 0;
            3'b110: return s > 0;
            default: return s <= 0;
        endcase
    endfunction

    function automatic logic [15:0] model_next(input logic [15:0] p, input logic [15:0] ins,
                                               input logic [15:0] v, input logic s, input logic r);
        logic [5:0]  o6;
        logic [15:0] ofs;
        if (r) return 16'h0;
        if (!s) return p;
        o6  = {ins[8:6], ins[2:0]};
        ofs = {{10{o6[5]}}, o6};
        if (ins[15:13] == 3'b111) return p + ofs;
        if (ins[15:13] == 3'b110 && cond_ok(ins[11:9], v)) return p + ofs;
        return p + 16'd1;
    endfunction

    function automatic logic [15:0] mk(input logic [2:0] pfx, input logic b12, input logic [2:0] c,
                                       input logic [2:0] saf, input logic [5:0] ofs);
        return {pfx, b12, c, ofs[5:3], saf, ofs[2:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s pc actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // drive at negedge, let one rising edge pass, sample at the following negedge
    task automatic cyc(input string tag, input logic r, input logic s,
                       input logic [15:0] ins, input logic [15:0] v);
        logic [15:0] exp;
        rst = r; step = s; instr = ins; sa_val = v;
        exp = model_next(mpc, ins, v, s, r);
        @(posedge clk);
        @(negedge clk);
        check(tag, pc, exp);
        mpc = exp;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        @(negedge clk);
        // R1: reset with step high and a jump present
        cyc("R1", 1'b1, 1'b1, mk(3'b111, 1'b0, 3'b000, 3'b000, 6'd9), 16'h0);
        cyc("R1", 1'b1, 1'b0, 16'hFFFF, 16'h8000);
        // R3: sequential steps from categories 000..101
        for (int k = 0; k < 6; k++)
            cyc("R3", 1'b0, 1'b1, mk(3'(k), 1'b1, 3'b011, 3'b101, 6'h2A), 16'h0);
        // R2: stall with a jump and a taken branch presented
        cyc("R2", 1'b0, 1'b0, mk(3'b111, 1'b0, 3'b000, 3'b000, 6'd20), 16'h0);
        cyc("R2", 1'b0, 1'b0, mk(3'b110, 1'b0, 3'b001, 3'b000, 6'd20), 16'h0);
        // R4/R5: offset extremes, source field and SA value ignored
        cyc("R4", 1'b0, 1'b1, mk(3'b111, 1'b0, 3'b000, 3'b111, 6'd31), 16'h8000);
        cyc("R4", 1'b0, 1'b1, mk(3'b111, 1'b1, 3'b101, 3'b010, 6'h20), 16'h1234);
        cyc("R4", 1'b0, 1'b1, mk(3'b111, 1'b0, 3'b000, 3'b111, 6'd0), 16'h0);
        cyc("R5", 1'b0, 1'b1, mk(3'b111, 1'b1, 3'b000, 3'b001, 6'd3), 16'h0);
        // R8: backward wrap below zero, then R3 wrap from all ones
        cyc("R8", 1'b0, 1'b1, mk(3'b111, 1'b0, 3'b000, 3'b000, 6'h3F - 6'(mpc)), 16'h0);
        cyc("R3", 1'b0, 1'b1, 16'h0000, 16'h0);
        cyc("R8", 1'b0, 1'b1, mk(3'b110, 1'b0, 3'b001, 3'b000, 6'h3E), 16'h0);
        cyc("R8", 1'b0, 1'b1, mk(3'b111, 1'b0, 3'b000, 3'b000, 6'd5), 16'h0);
        // R6/R7/R9: condition table at signed corner values, bit 12 both ways
        for (int c = 0; c < 8; c++)
            for (int b = 0; b < 2; b++) begin
                cyc("R6", 1'b0, 1'b1, mk(3'b110, 1'(b), 3'(c), 3'b100, 6'd5), 16'h0000);
                cyc("R7", 1'b0, 1'b1, mk(3'b110, 1'(b), 3'(c), 3'b001, 6'h3C), 16'h0001);
                cyc("R9", 1'b0, 1'b1, mk(3'b110, 1'(b), 3'(c), 3'b010, 6'd7), 16'hFFFF);
                cyc("R9", 1'b0, 1'b1, mk(3'b110, 1'(b), 3'(c), 3'b011, 6'h39), 16'h8000);
                cyc("R9", 1'b0, 1'b1, mk(3'b110, 1'(b), 3'(c), 3'b110, 6'd2), 16'h7FFF);
            end
        // R1: reset mid-run
        cyc("R1", 1'b1, 1'b1, 16'h0, 16'h0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] ins;
            logic [15:0] v;
            logic r;
            logic s;
            ins = 16'($urandom);
            if ($urandom_range(0, 2) == 0) ins[15:13] = 3'b110;
            else if ($urandom_range(0, 3) == 0) ins[15:13] = 3'b111;
            case ($urandom_range(0, 5))
                0: v = 16'h0;
                1: v = 16'h8000;
                2: v = 16'h7FFF;
                3: v = 16'hFFFF;
                default: v = 16'($urandom);
            endcase
            r = ($urandom_range(0, 99) == 0);
            s = ($urandom_range(0, 4) != 0);
            cyc(r ? "R1" : (!s ? "R2" : (ins[15:13] == 3'b111 ? "R5" :
                (ins[15:13] == 3'b110 ? "R7" : "R3"))), r, s, ins, v);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule